// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Pin Takeover

This block is one 8-bit bidirectional I/O port. Software drives it through a small register bus. The port holds three registers. A data latch supplies the value each output pin drives. A direction register decides, pin by pin, whether the output driver is on. A control register holds one bit that switches off the pull-up on pin 0. Pad inputs pass through a two-flop synchroniser. The synchronised values feed the data read-back path, the peripheral receive taps and an interrupt tap.

Two peripherals can take over fixed pins. With the SPI enable set, pins 2 to 5 carry MISO, MOSI, slave select and serial clock. Their drive direction then depends on whether the SPI is master or slave. With the serial-interface enable set, pin 6 drives transmit data and pin 7 becomes the receive input. Pin 0 always feeds the interrupt tap, whatever its direction or use.

Register offsets: data latch at 0x02, direction register at 0x06, pull-up control at 0x0A.

Top module: `gpio_ovr_port`

## Requirements
- R1: With no peripheral override active, a direction bit of 1 turns on the output enable of its pin, a direction bit of 0 turns it off, and `pad_out` shows the data latch.
- R2: Reset clears the direction register (offset 0x06) and the pull-up-off bit (bit 0 at offset 0x0A). Every `pad_oe` bit is therefore 0 after reset.
- R3: Reset leaves the data latch unchanged. A value written before reset still reaches `pad_out` after reset.
- R4: A write to the data latch (offset 0x02) takes effect whatever the direction bits are. When a pin's direction bit later goes to 1, that pin drives the preloaded value in the same cycle its enable rises.
- R5: A read of offset 0x02 returns, per bit, the latch value where the direction bit is 1 and the synchronised pad value where it is 0. A read of 0x06 returns the direction register. A read of 0x0A returns the pull-up-off bit in bit 0 and zeros elsewhere.
- R6: With `spi_en`=1 and `spi_master`=1, pins 3, 4 and 5 are enabled outputs and pin 2 is an input. Pins 2, 3, 4 and 5 drive `spi_miso_drv`, `spi_mosi_drv`, `spi_ss_drv` and `spi_sck_drv`.
- R7: With `spi_en`=1 and `spi_master`=0, pin 2 is an enabled output and pins 3, 4 and 5 are inputs. The pins keep the same value sources as in R6.
- R8: With `sci_en`=1, pin 6 is an enabled output driving `sci_txd`, and pin 7 is an input. Pins not under any override keep the behaviour of R1.
- R9: `irq_tap` equals the value on `pad_in[0]` two clock edges earlier, for every direction setting and override.
- R10: `pad_pu[0]` is 1 while the pull-up-off bit is 0 and is 0 while that bit is 1. `pad_pu[7:1]` are always 0.
- R11: `spi_miso_rx`, `spi_mosi_rx`, `spi_ss_rx`, `spi_sck_rx` and `sci_rxd` carry the synchronised values of pins 2, 3, 4, 5 and 7, two clock edges after the pad.
- R12: A write to any other offset changes no register, and a read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pad_in | input | 8 | Pad input values |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |
| spi_en | input | 1 | SPI takes over pins 2 to 5 |
| spi_master | input | 1 | SPI is master (1) or slave (0) |
| spi_miso_drv | input | 1 | SPI value for pin 2 |
| spi_mosi_drv | input | 1 | SPI value for pin 3 |
| spi_ss_drv | input | 1 | SPI value for pin 4 |
| spi_sck_drv | input | 1 | SPI value for pin 5 |
| spi_miso_rx | output | 1 | Synchronised pin 2 |
| spi_mosi_rx | output | 1 | Synchronised pin 3 |
| spi_ss_rx | output | 1 | Synchronised pin 4 |
| spi_sck_rx | output | 1 | Synchronised pin 5 |
| sci_en | input | 1 | Serial interface takes over pins 6 and 7 |
| sci_txd | input | 1 | Transmit value for pin 6 |
| sci_rxd | output | 1 | Synchronised pin 7 |
| irq_tap | output | 1 | Synchronised pin 0 for the interrupt module |

## Verification
All 256 direction patterns are tried, each with a latch value and a pad value derived from it. This separates the latch bits from the pad bits in read-back and shows that no output enable leaks between pins. All eight combinations of the three override controls are crossed with all 32 peripheral drive patterns, under direction registers of all zeros and all ones. This shows which pins a peripheral owns and which still follow the port registers. All 256 pad patterns are stepped through one at a time, and each input tap is sampled after one edge and after two. This confirms the two-edge latency and sets it apart from a one-edge or combinational path.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
    localparam int PORT_W   = 8;
    localparam int PIN_IRQ  = 0;
    localparam int PIN_MISO = 2;
    localparam int PIN_MOSI = 3;
    localparam int PIN_SS   = 4;
    localparam int PIN_SCK  = 5;
    localparam int PIN_TXD  = 6;
    localparam int PIN_RXD  = 7;

    typedef logic [PORT_W-1:0] port_t;

    typedef struct packed {
        port_t latch;
        port_t dir;
        logic  pu_off;
    } regs_t;
endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    // No reset: the chain fills with real pad values while reset is held.
    always_ff @(posedge clk) begin
        for (int k = 0; k < STAGES; k++) begin
            stg_q[k] <= stg_d[k];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
    import gpio_ovr_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_DATA = 'h02,
    parameter logic [ADDR_W-1:0] ADDR_DIR  = 'h06,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 'h0A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  port_t             wdata,
    input  logic              we,
    input  port_t             pin_sync,
    output port_t             rdata,
    output port_t             latch,
    output port_t             dir,
    output logic              pu_off
);
    regs_t st_d, st_q;
    logic  hit_data, hit_dir, hit_ctrl;

    assign hit_data = (addr == ADDR_DATA);
    assign hit_dir  = (addr == ADDR_DIR);
    assign hit_ctrl = (addr == ADDR_CTRL);

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (hit_data) st_d.latch  = wdata;
            if (hit_dir)  st_d.dir    = wdata;
            if (hit_ctrl) st_d.pu_off = wdata[0];
        end
    end

    // The latch is deliberately left out of the reset branch: it keeps its value.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.dir    <= '0;
            st_q.pu_off <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_data)      rdata = (st_q.latch & st_q.dir) | (pin_sync & ~st_q.dir);
        else if (hit_dir)  rdata = st_q.dir;
        else if (hit_ctrl) rdata = {{(PORT_W-1){1'b0}}, st_q.pu_off};
    end

    assign latch  = st_q.latch;
    assign dir    = st_q.dir;
    assign pu_off = st_q.pu_off;

    assert_dir_cleared_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dir == '0 && pu_off == 1'b0));

    assert_latch_write_any_dir_R4: assert property (@(posedge clk) disable iff (rst)
        (we && hit_data) |=> (latch == $past(wdata)));

    assert_unmapped_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        (we && !hit_data && !hit_dir && !hit_ctrl) |=> (dir == $past(dir) && pu_off == $past(pu_off)
                                                       && latch == $past(latch)));
endmodule

// File: rtl/gpio_ovr_pinmux.sv
module gpio_ovr_pinmux
    import gpio_ovr_pkg::*;
(
    input  port_t latch,
    input  port_t dir,
    input  logic  pu_off,
    input  logic  spi_en,
    input  logic  spi_master,
    input  logic  [3:0] spi_drv,   // {sck, ss, mosi, miso}
    input  logic  sci_en,
    input  logic  sci_txd,
    output port_t pad_out,
    output port_t pad_oe,
    output port_t pad_pu
);
    always_comb begin
        pad_out = latch;
        pad_oe  = dir;
        if (spi_en) begin
            pad_out[PIN_MISO] = spi_drv[0];
            pad_out[PIN_MOSI] = spi_drv[1];
            pad_out[PIN_SS]   = spi_drv[2];
            pad_out[PIN_SCK]  = spi_drv[3];
            pad_oe[PIN_MISO]  = !spi_master;
            pad_oe[PIN_MOSI]  = spi_master;
            pad_oe[PIN_SS]    = spi_master;
            pad_oe[PIN_SCK]   = spi_master;
        end
        if (sci_en) begin
            pad_out[PIN_TXD] = sci_txd;
            pad_oe[PIN_TXD]  = 1'b1;
            pad_oe[PIN_RXD]  = 1'b0;
        end
    end

    generate
        for (genvar i = 0; i < PORT_W; i++) begin : g_pu
            if (i == PIN_IRQ) begin : g_irq_pu
                assign pad_pu[i] = !pu_off;
            end else begin : g_no_pu
                assign pad_pu[i] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
    import gpio_ovr_pkg::*;
#(
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] ADDR_DATA   = 'h02,
    parameter logic [ADDR_W-1:0] ADDR_DIR    = 'h06,
    parameter logic [ADDR_W-1:0] ADDR_CTRL   = 'h0A,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        pad_in,
    output logic [7:0]        pad_out,
    output logic [7:0]        pad_oe,
    output logic [7:0]        pad_pu,
    input  logic              spi_en,
    input  logic              spi_master,
    input  logic              spi_miso_drv,
    input  logic              spi_mosi_drv,
    input  logic              spi_ss_drv,
    input  logic              spi_sck_drv,
    output logic              spi_miso_rx,
    output logic              spi_mosi_rx,
    output logic              spi_ss_rx,
    output logic              spi_sck_rx,
    input  logic              sci_en,
    input  logic              sci_txd,
    output logic              sci_rxd,
    output logic              irq_tap
);
    port_t pin_sync, latch, dir;
    logic  pu_off;

    gpio_ovr_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (pad_in),
        .dout (pin_sync)
    );

    gpio_ovr_regs #(
        .ADDR_W(ADDR_W), .ADDR_DATA(ADDR_DATA), .ADDR_DIR(ADDR_DIR), .ADDR_CTRL(ADDR_CTRL)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .we       (bus_we),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata),
        .latch    (latch),
        .dir      (dir),
        .pu_off   (pu_off)
    );

    gpio_ovr_pinmux u_mux (
        .latch      (latch),
        .dir        (dir),
        .pu_off     (pu_off),
        .spi_en     (spi_en),
        .spi_master (spi_master),
        .spi_drv    ({spi_sck_drv, spi_ss_drv, spi_mosi_drv, spi_miso_drv}),
        .sci_en     (sci_en),
        .sci_txd    (sci_txd),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .pad_pu     (pad_pu)
    );

    assign irq_tap     = pin_sync[PIN_IRQ];
    assign spi_miso_rx = pin_sync[PIN_MISO];
    assign spi_mosi_rx = pin_sync[PIN_MOSI];
    assign spi_ss_rx   = pin_sync[PIN_SS];
    assign spi_sck_rx  = pin_sync[PIN_SCK];
    assign sci_rxd     = pin_sync[PIN_RXD];

    assert_plain_dir_R1: assert property (@(posedge clk) disable iff (rst)
        (!spi_en && !sci_en) |-> (pad_oe == dir && pad_out == latch));

    assert_spi_master_R6: assert property (@(posedge clk) disable iff (rst)
        (spi_en && spi_master) |-> (pad_oe[5:2] == 4'b1110 && pad_out[3] == spi_mosi_drv));

    assert_spi_slave_R7: assert property (@(posedge clk) disable iff (rst)
        (spi_en && !spi_master) |-> (pad_oe[5:2] == 4'b0001 && pad_out[2] == spi_miso_drv));

    assert_sci_pins_R8: assert property (@(posedge clk) disable iff (rst)
        sci_en |-> (pad_oe[7:6] == 2'b01 && pad_out[6] == sci_txd));

    assert_pullup_R10: assert property (@(posedge clk) disable iff (rst)
        (pad_pu[0] == !pu_off) && (pad_pu[7:1] == 7'd0));

    generate
        if (SYNC_STAGES == 2) begin : g_lat_chk
            assert_irq_latency_R9: assert property (@(posedge clk) disable iff (rst)
                irq_tap == $past(pad_in[0], 2));
        end
    endgenerate
endmodule

// File: tb/gpio_ovr_port_tb.sv
module gpio_ovr_port_tb;
    localparam logic [7:0] A_DATA = 8'h02, A_DIR = 8'h06, A_CTRL = 8'h0A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] bus_addr = A_DATA, bus_wdata = '0, bus_rdata;
    logic bus_we = 1'b0;
    logic [7:0] pad_in = '0, pad_out, pad_oe, pad_pu;
    logic spi_en = 0, spi_master = 0, spi_miso_drv = 0, spi_mosi_drv = 0, spi_ss_drv = 0, spi_sck_drv = 0;
    logic spi_miso_rx, spi_mosi_rx, spi_ss_rx, spi_sck_rx;
    logic sci_en = 0, sci_txd = 0, sci_rxd, irq_tap;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    gpio_ovr_port u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .spi_en(spi_en), .spi_master(spi_master), .spi_miso_drv(spi_miso_drv),
        .spi_mosi_drv(spi_mosi_drv), .spi_ss_drv(spi_ss_drv), .spi_sck_drv(spi_sck_drv),
        .spi_miso_rx(spi_miso_rx), .spi_mosi_rx(spi_mosi_rx), .spi_ss_rx(spi_ss_rx),
        .spi_sck_rx(spi_sck_rx), .sci_en(sci_en), .sci_txd(sci_txd), .sci_rxd(sci_rxd),
        .irq_tap(irq_tap)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = A_DATA;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
        bus_addr = A_DATA;
    endtask

    function automatic logic [7:0] exp_oe(logic [7:0] d, logic se, logic sm, logic ce);
        logic [7:0] r = d;
        if (se) r[5:2] = sm ? 4'b1110 : 4'b0001;
        if (ce) r[7:6] = 2'b01;
        return r;
    endfunction

    function automatic logic [7:0] exp_out(logic [7:0] l, logic se, logic ce, logic [3:0] drv, logic tx);
        logic [7:0] r = l;
        if (se) r[5:2] = drv;
        if (ce) r[6] = tx;
        return r;
    endfunction

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R2: reset state
        check("R2 oe after reset", pad_oe, 8'h00);
        bus_read(A_DIR, v);  check("R2 dir after reset", v, 8'h00);
        bus_read(A_CTRL, v); check("R2 ctrl after reset", v, 8'h00);
        check("R10 pull-up default", pad_pu, 8'h01);

        // R3: latch survives reset
        bus_write(A_DATA, 8'hA5);
        bus_write(A_DIR, 8'h0F);
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        check("R2 oe cleared by reset", pad_oe, 8'h00);
        check("R3 latch kept over reset", pad_out, 8'hA5);
        bus_write(A_DIR, 8'hFF);
        bus_read(A_DATA, v); check("R3 latch read after reset", v, 8'hA5);

        // R4: preload while input, then switch to output
        bus_write(A_DIR, 8'h00);
        bus_write(A_DATA, 8'h3C);
        check("R4 oe still off", pad_oe, 8'h00);
        check("R4 preload visible before enable", pad_out, 8'h3C);
        bus_write(A_DIR, 8'hFF);
        check("R4 oe on", pad_oe, 8'hFF);
        check("R4 value when oe rises", pad_out, 8'h3C);

        // R10: pull-up control
        bus_write(A_CTRL, 8'hFF);
        check("R10 pull-up off", pad_pu, 8'h00);
        bus_read(A_CTRL, v); check("R5 ctrl readback", v, 8'h01);
        bus_write(A_CTRL, 8'h00);
        check("R10 pull-up back on", pad_pu, 8'h01);

        // R12: unmapped offsets
        bus_write(A_DIR, 8'h5A);
        bus_write(A_DATA, 8'hC3);
        for (int a = 0; a < 256; a += 17) begin
            if (a == A_DATA || a == A_DIR || a == A_CTRL) continue;
            bus_write(a[7:0], 8'hFF);
            bus_read(a[7:0], v); check("R12 unmapped read", v, 8'h00);
        end
        bus_read(A_DIR, v);  check("R12 dir untouched", v, 8'h5A);
        bus_read(A_CTRL, v); check("R12 ctrl untouched", v, 8'h00);
        check("R12 latch untouched", pad_out, 8'hC3);

        // R1 / R5: sweep all direction patterns
        for (int d = 0; d < 256; d++) begin
            logic [7:0] l, p;
            l = 8'(d * 7 + 13);
            p = ~8'(d) ^ 8'h5A;
            bus_write(A_DATA, l);
            bus_write(A_DIR, d[7:0]);
            pad_in = p;
            repeat (2) @(posedge clk);
            @(negedge clk);
            check("R1 oe follows dir", pad_oe, d[7:0]);
            check("R1 out follows latch", pad_out, l);
            bus_read(A_DATA, v); check("R5 data read mix", v, (l & d[7:0]) | (p & ~d[7:0]));
            bus_read(A_DIR, v);  check("R5 dir read", v, d[7:0]);
        end

        // R6 / R7 / R8: override sweep
        for (int dr = 0; dr < 2; dr++) begin
            logic [7:0] dv, lv;
            dv = dr ? 8'hFF : 8'h00;
            lv = dr ? 8'h96 : 8'h69;
            bus_write(A_DATA, lv);
            bus_write(A_DIR, dv);
            for (int c = 0; c < 8; c++) begin
                for (int s = 0; s < 32; s++) begin
                    @(negedge clk);
                    spi_en = c[0]; spi_master = c[1]; sci_en = c[2];
                    {spi_sck_drv, spi_ss_drv, spi_mosi_drv, spi_miso_drv} = s[3:0];
                    sci_txd = s[4];
                    #1;
                    if (c[0] && c[1])      check("R6 master oe", pad_oe, exp_oe(dv, 1'b1, 1'b1, c[2]));
                    else if (c[0])         check("R7 slave oe", pad_oe, exp_oe(dv, 1'b1, 1'b0, c[2]));
                    else                   check("R8 sci/plain oe", pad_oe, exp_oe(dv, 1'b0, 1'b0, c[2]));
                    if (c[2])              check("R8 sci out", pad_out, exp_out(lv, c[0], 1'b1, s[3:0], s[4]));
                    else                   check("R6 spi/plain out", pad_out, exp_out(lv, c[0], 1'b0, s[3:0], s[4]));
                end
            end
        end

        // R9 / R11: input taps, with all overrides on and all pins outputs
        spi_en = 1'b1; sci_en = 1'b1; spi_master = 1'b1;
        for (int p = 0; p < 256; p++) begin
            logic [7:0] prev;
            prev = pad_in;
            @(negedge clk); pad_in = p[7:0];
            @(posedge clk); @(negedge clk);
            check("R9 irq not yet updated", {7'd0, irq_tap}, {7'd0, prev[0]});
            @(posedge clk); @(negedge clk);
            check("R9 irq after two edges", {7'd0, irq_tap}, {7'd0, p[0]});
            check("R11 peripheral taps",
                  {3'd0, sci_rxd, spi_sck_rx, spi_ss_rx, spi_mosi_rx, spi_miso_rx},
                  {3'd0, p[7], p[5], p[4], p[3], p[2]});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule